// File: doc/BRIEF.md
# Two-Level I/O Address Translator

This block maps addresses issued by inbound devices onto physical memory addresses, one request at a time. A bank of first-level entries is held in on-chip registers and written through a small 32-bit register port. Each entry covers one 32 MB slice of the bus address space. An entry either describes that whole slice as a single large page, or points at a second-level table in memory that holds one 32-bit entry for each 4 KB page of the slice. A translation window register limits which bus addresses may be translated at all, and a control register switches translation on. While translation is off, addresses pass through unchanged.

Lookups arrive on a valid/ready request channel and leave on a valid/ready response channel. A request is accepted only while `req_ready` is high, and `req_ready` stays low from acceptance until the response has been taken. A held `resp_valid` keeps its payload steady until `resp_ready` is seen, and a held `mem_req_valid` keeps its address steady until `mem_req_ready` is seen. When a second-level entry is needed, the block issues one word read on its memory port and waits for `mem_rsp_valid`. It keeps no copies of table entries.

Top module: `iotrans_top`

## Requirements
- R1: After reset the control, window and all first-level registers read as zero, so translation is off. `req_ready` is 1, and `resp_valid` and `mem_req_valid` are 0.
- R2: While the enable bit (bit 8 of the control register at byte offset 0x000) is clear, an accepted request is answered in the next cycle. The answer is the request address zero-extended, with fault, cached and priority all 0, and no memory read is made.
- R3: The window field (bits 1:0 of the register at offset 0x004) sets which addresses may be translated. Code 1 allows addresses below 2 GB. Code 3 allows the full 128 GB bus space. Codes 0 and 2 allow addresses below 256 MB. An enabled request outside the window gets a fault response in the next cycle, with physical address, cached and priority all 0, and no memory read.
- R4: A first-level entry whose valid bit (bit 30) is clear gives the same next-cycle fault response, even when bit 31 is set.
- R5: A first-level entry with bit 31 and bit 30 set is a large page. The response comes in the next cycle with physical address {entry[29:13], addr[24:0]}, cached = entry[1] and priority = entry[0]. Entry bits 12:2 are ignored, and no memory read is made.
- R6: A valid first-level entry with bit 31 clear triggers exactly one memory read. The read address is {entry[29:3], addr[24:12], 2'b00}, so entry bits 2:0 are ignored.
- R7: When the second-level word has bit 31 set, the response carries physical address {word[29:0], addr[11:0]}, cached = word[30] and priority 0. When bit 31 is clear, the response is a fault with physical address 0.
- R8: The first-level entry is selected by addr[30:25]. In the 128 GB window, addresses at or above 2 GB therefore reuse entries every 2 GB.
- R9: Only one lookup is in flight. `req_ready` is low while a response or memory read is pending. A stalled response or memory request keeps its valid high and its payload stable.
- R10: Registers are decoded on reg_addr[8:2]. Word 0 keeps only bit 8, word 1 keeps only bits 1:0, and words 64..127 are first-level entries 0..63 held in full. Writes to any other word are ignored and that word reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 9 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Block idle and able to accept a lookup |
| req_addr | input | 37 | Bus address to translate |
| resp_valid | output | 1 | Lookup result valid |
| resp_ready | input | 1 | Consumer takes the result |
| resp_paddr | output | 42 | Physical address (0 on fault) |
| resp_fault | output | 1 | Translation fault |
| resp_cached | output | 1 | Cached attribute |
| resp_prio | output | 1 | Priority attribute |
| mem_req_valid | output | 1 | Second-level read request valid |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 42 | Byte address of the second-level word |
| mem_rsp_valid | input | 1 | Read data valid (one cycle) |
| mem_rsp_data | input | 32 | Second-level word |

## Verification
Pass-through answers, window faults, invalid-entry faults and large-page answers are all due one cycle after the request handshake. The bench notes the cycle in which it raises a request and checks that the result is taken exactly one cycle later. A table walk raises its memory read one cycle after acceptance and answers one cycle after the read data. The bench's memory model compares every read address against an ordered queue of expected addresses and reports any read that is not due. All outputs are sampled just after the falling edge, so each check reads values that settled after the last rising edge. During the stall tests the held valid, payload and `req_ready` are checked on each stalled cycle.

// File: rtl/iotrans_pkg.sv
package iotrans_pkg;
  // first-level entry fields
  localparam int L1_LARGE_BIT   = 31;
  localparam int L1_VALID_BIT   = 30;
  localparam int LP_CACHED_BIT  = 1;
  localparam int LP_PRIO_BIT    = 0;
  // second-level entry fields
  localparam int L2_VALID_BIT   = 31;
  localparam int L2_CACHED_BIT  = 30;
  // page-number field width shared by both levels
  localparam int ENTRY_PPN_W    = 30;
  // control register enable bit
  localparam int CTRL_EN_BIT    = 8;

  typedef enum logic [1:0] {
    WIN_256M = 2'd0,
    WIN_2G   = 2'd1,
    WIN_RSVD = 2'd2,
    WIN_128G = 2'd3
  } win_code_e;

  typedef enum logic [1:0] {
    WS_IDLE,
    WS_MEM_REQ,
    WS_MEM_WAIT,
    WS_RESP
  } walk_state_e;
endpackage

// File: rtl/iotrans_regs.sv
module iotrans_regs
  import iotrans_pkg::*;
#(
  parameter int NUM_L1 = 64,
  parameter int REG_AW = 9
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      reg_wr,
  input  logic [REG_AW-1:0]         reg_addr,
  input  logic [31:0]               reg_wdata,
  output logic [31:0]               reg_rdata,
  input  logic [$clog2(NUM_L1)-1:0] l1_sel,
  output logic [31:0]               l1_entry,
  output logic                      xlat_en,
  output logic [1:0]                win_code
);
  localparam int L1_IDX_W = $clog2(NUM_L1);
  localparam int WORD_W   = REG_AW - 2;

  logic [WORD_W-1:0]   word;
  logic                l1_hit;
  logic [L1_IDX_W-1:0] l1_wsel;
  logic                ctrl_hit, win_hit;
  logic                en_q;
  logic [1:0]          win_q;
  logic [31:0]         l1_vec [NUM_L1];
  logic [1:0]          unused_lsb;

  assign word       = reg_addr[REG_AW-1:2];
  assign unused_lsb = reg_addr[1:0];
  assign l1_hit     = word[WORD_W-1];
  assign l1_wsel    = word[L1_IDX_W-1:0];
  assign ctrl_hit   = (word == WORD_W'(0));
  assign win_hit    = (word == WORD_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      win_q <= 2'b00;
    end else if (reg_wr) begin
      if (ctrl_hit) en_q  <= reg_wdata[CTRL_EN_BIT];
      if (win_hit)  win_q <= reg_wdata[1:0];
    end
  end

  for (genvar g = 0; g < NUM_L1; g++) begin : g_l1
    logic [31:0] entry_q;
    always_ff @(posedge clk) begin
      if (!rst_n)
        entry_q <= '0;
      else if (reg_wr && l1_hit && (l1_wsel == L1_IDX_W'(g)))
        entry_q <= reg_wdata;
    end
    assign l1_vec[g] = entry_q;
  end

  always_comb begin
    reg_rdata = '0;
    if (l1_hit)
      reg_rdata = l1_vec[l1_wsel];
    else if (ctrl_hit)
      reg_rdata[CTRL_EN_BIT] = en_q;
    else if (win_hit)
      reg_rdata[1:0] = win_q;
  end

  assign l1_entry = l1_vec[l1_sel];
  assign xlat_en  = en_q;
  assign win_code = win_q;
endmodule

// File: rtl/iotrans_window.sv
module iotrans_window
  import iotrans_pkg::*;
#(
  parameter int BUS_AW      = 37,
  parameter int SMALL_LOG2  = 28,
  parameter int MID_LOG2    = 31
) (
  input  logic [BUS_AW-1:0] addr,
  input  logic [1:0]        win_code,
  output logic              in_win
);
  always_comb begin
    case (win_code)
      WIN_2G:   in_win = (addr[BUS_AW-1:MID_LOG2] == '0);
      WIN_128G: in_win = 1'b1;
      default:  in_win = (addr[BUS_AW-1:SMALL_LOG2] == '0); // 256 MB and reserved code
    endcase
  end
endmodule

// File: rtl/iotrans_walk.sv
module iotrans_walk
  import iotrans_pkg::*;
#(
  parameter int BUS_AW       = 37,
  parameter int PAGE_SHIFT   = 12,
  parameter int REGION_SHIFT = 25,
  parameter int PA_W         = ENTRY_PPN_W + PAGE_SHIFT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [BUS_AW-1:0] req_addr,
  input  logic              xlat_en,
  input  logic              win_ok,
  input  logic [31:0]       l1_entry,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [PA_W-1:0]   mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [31:0]       mem_rsp_data,
  output logic              resp_valid,
  input  logic              resp_ready,
  output logic [PA_W-1:0]   resp_paddr,
  output logic              resp_fault,
  output logic              resp_cached,
  output logic              resp_prio
);
  localparam int IDX_W    = REGION_SHIFT - PAGE_SHIFT;
  localparam int TBL_DROP = IDX_W + 2 - PAGE_SHIFT;

  walk_state_e           state_q;
  logic [PAGE_SHIFT-1:0] off_q;
  logic [PA_W-1:0]       mem_addr_q;
  logic [PA_W-1:0]       paddr_q;
  logic                  fault_q, cached_q, prio_q;
  logic                  unused_entry_bit;

  assign unused_entry_bit = l1_entry[2];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= WS_IDLE;
      off_q      <= '0;
      mem_addr_q <= '0;
      paddr_q    <= '0;
      fault_q    <= 1'b0;
      cached_q   <= 1'b0;
      prio_q     <= 1'b0;
    end else begin
      case (state_q)
        WS_IDLE: begin
          if (req_valid) begin
            off_q    <= req_addr[PAGE_SHIFT-1:0];
            fault_q  <= 1'b0;
            cached_q <= 1'b0;
            prio_q   <= 1'b0;
            paddr_q  <= '0;
            if (!xlat_en) begin
              paddr_q <= PA_W'(req_addr);
              state_q <= WS_RESP;
            end else if (!win_ok || !l1_entry[L1_VALID_BIT]) begin
              fault_q <= 1'b1;
              state_q <= WS_RESP;
            end else if (l1_entry[L1_LARGE_BIT]) begin
              paddr_q  <= {l1_entry[ENTRY_PPN_W-1:IDX_W], req_addr[REGION_SHIFT-1:0]};
              cached_q <= l1_entry[LP_CACHED_BIT];
              prio_q   <= l1_entry[LP_PRIO_BIT];
              state_q  <= WS_RESP;
            end else begin
              mem_addr_q <= {l1_entry[ENTRY_PPN_W-1:TBL_DROP],
                             req_addr[REGION_SHIFT-1:PAGE_SHIFT], 2'b00};
              state_q    <= WS_MEM_REQ;
            end
          end
        end
        WS_MEM_REQ: begin
          if (mem_req_ready) state_q <= WS_MEM_WAIT;
        end
        WS_MEM_WAIT: begin
          if (mem_rsp_valid) begin
            prio_q  <= 1'b0;
            state_q <= WS_RESP;
            if (mem_rsp_data[L2_VALID_BIT]) begin
              paddr_q  <= {mem_rsp_data[ENTRY_PPN_W-1:0], off_q};
              cached_q <= mem_rsp_data[L2_CACHED_BIT];
              fault_q  <= 1'b0;
            end else begin
              paddr_q  <= '0;
              cached_q <= 1'b0;
              fault_q  <= 1'b1;
            end
          end
        end
        WS_RESP: begin
          if (resp_ready) state_q <= WS_IDLE;
        end
        default: state_q <= WS_IDLE;
      endcase
    end
  end

  assign req_ready     = (state_q == WS_IDLE);
  assign mem_req_valid = (state_q == WS_MEM_REQ);
  assign mem_req_addr  = mem_addr_q;
  assign resp_valid    = (state_q == WS_RESP);
  assign resp_paddr    = paddr_q;
  assign resp_fault    = fault_q;
  assign resp_cached   = cached_q;
  assign resp_prio     = prio_q;
endmodule

// File: rtl/iotrans_top.sv
module iotrans_top
  import iotrans_pkg::*;
#(
  parameter int  NUM_L1       = 64,
  parameter int  PAGE_SHIFT   = 12,
  parameter int  REGION_SHIFT = 25,
  parameter int  BUS_AW       = 37,
  parameter int  WIN_SMALL_LOG2 = 28,
  parameter int  WIN_MID_LOG2   = 31,
  localparam int L1_IDX_W     = $clog2(NUM_L1),
  localparam int REG_AW       = L1_IDX_W + 3,
  localparam int PA_W         = ENTRY_PPN_W + PAGE_SHIFT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [BUS_AW-1:0] req_addr,
  output logic              resp_valid,
  input  logic              resp_ready,
  output logic [PA_W-1:0]   resp_paddr,
  output logic              resp_fault,
  output logic              resp_cached,
  output logic              resp_prio,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [PA_W-1:0]   mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [31:0]       mem_rsp_data
);
  logic [L1_IDX_W-1:0] l1_sel;
  logic [31:0]         l1_entry;
  logic                xlat_en;
  logic [1:0]          win_code;
  logic                win_ok;

  assign l1_sel = req_addr[REGION_SHIFT+L1_IDX_W-1:REGION_SHIFT];

  iotrans_regs #(.NUM_L1(NUM_L1), .REG_AW(REG_AW)) regs_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .l1_sel(l1_sel),
    .l1_entry(l1_entry), .xlat_en(xlat_en), .win_code(win_code)
  );

  iotrans_window #(.BUS_AW(BUS_AW), .SMALL_LOG2(WIN_SMALL_LOG2),
                   .MID_LOG2(WIN_MID_LOG2)) win_i (
    .addr(req_addr), .win_code(win_code), .in_win(win_ok)
  );

  iotrans_walk #(.BUS_AW(BUS_AW), .PAGE_SHIFT(PAGE_SHIFT),
                 .REGION_SHIFT(REGION_SHIFT), .PA_W(PA_W)) walk_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .xlat_en(xlat_en), .win_ok(win_ok),
    .l1_entry(l1_entry), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .resp_valid(resp_valid), .resp_ready(resp_ready), .resp_paddr(resp_paddr),
    .resp_fault(resp_fault), .resp_cached(resp_cached), .resp_prio(resp_prio)
  );
endmodule

// File: rtl/iotrans_chk.sv
module iotrans_chk #(
  parameter int PA_W       = 42,
  parameter int BUS_AW     = 37,
  parameter int PAGE_SHIFT = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [BUS_AW-1:0] req_addr,
  input logic              xlat_en,
  input logic              resp_valid,
  input logic              resp_ready,
  input logic [PA_W-1:0]   resp_paddr,
  input logic              resp_fault,
  input logic              resp_cached,
  input logic              resp_prio,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic [PA_W-1:0]   mem_req_addr
);
  logic [PAGE_SHIFT-1:0] cap_off;
  logic                  cap_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_off <= '0;
      cap_en  <= 1'b0;
    end else if (req_valid && req_ready) begin
      cap_off <= req_addr[PAGE_SHIFT-1:0];
      cap_en  <= xlat_en;
    end
  end

  assert_resp_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && !resp_ready |=> resp_valid && $stable(resp_paddr) &&
    $stable(resp_fault) && $stable(resp_cached) && $stable(resp_prio));

  assert_memreq_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  assert_single_walk_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid || mem_req_valid) |-> !req_ready);

  assert_fault_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && resp_fault |-> (resp_paddr == '0) && !resp_cached && !resp_prio);

  assert_offset_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && !resp_fault |-> resp_paddr[PAGE_SHIFT-1:0] == cap_off);

  assert_no_walk_when_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> cap_en);

  assert_pass_no_fault_R2: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && !cap_en |-> !resp_fault && !resp_cached && !resp_prio);
endmodule

bind iotrans_top iotrans_chk #(.PA_W(PA_W), .BUS_AW(BUS_AW), .PAGE_SHIFT(PAGE_SHIFT)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_addr(req_addr), .xlat_en(xlat_en), .resp_valid(resp_valid),
  .resp_ready(resp_ready), .resp_paddr(resp_paddr), .resp_fault(resp_fault),
  .resp_cached(resp_cached), .resp_prio(resp_prio),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_addr(mem_req_addr)
);

// File: tb/iotrans_top_tb_top.sv
`timescale 1ns/1ps
module iotrans_top_tb_top;
  localparam int BUS_AW = 37;
  localparam int PA_W   = 42;
  localparam int REG_AW = 9;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              reg_wr = 1'b0;
  logic [REG_AW-1:0] reg_addr = '0;
  logic [31:0]       reg_wdata = '0;
  logic [31:0]       reg_rdata;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic [BUS_AW-1:0] req_addr = '0;
  logic              resp_valid;
  logic              resp_ready = 1'b1;
  logic [PA_W-1:0]   resp_paddr;
  logic              resp_fault, resp_cached, resp_prio;
  logic              mem_req_valid;
  logic              mem_req_ready = 1'b1;
  logic [PA_W-1:0]   mem_req_addr;
  logic              mem_rsp_valid = 1'b0;
  logic [31:0]       mem_rsp_data = '0;

  always #4 clk = ~clk;

  iotrans_top dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_valid(req_valid),
    .req_ready(req_ready), .req_addr(req_addr), .resp_valid(resp_valid),
    .resp_ready(resp_ready), .resp_paddr(resp_paddr), .resp_fault(resp_fault),
    .resp_cached(resp_cached), .resp_prio(resp_prio),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data)
  );

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit finished = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    logic [PA_W-1:0] paddr;
    logic            fault;
    logic            cached;
    logic            prio;
    bit              chk_lat;
    int              issue;
  } exp_t;

  exp_t            sb[$];
  string           sb_tag[$];
  logic [PA_W-1:0] mem_exp[$];
  logic [31:0]     l2mem [logic [PA_W-1:0]];

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [PA_W-1:0] large_pa(input logic [31:0] e, input logic [BUS_AW-1:0] a);
    return {e[29:13], a[24:0]};
  endfunction
  function automatic logic [PA_W-1:0] l2_addr(input logic [31:0] e, input logic [BUS_AW-1:0] a);
    return {e[29:3], a[24:12], 2'b00};
  endfunction
  function automatic logic [PA_W-1:0] l2_pa(input logic [31:0] d, input logic [BUS_AW-1:0] a);
    return {d[29:0], a[11:0]};
  endfunction

  task automatic reg_write(input logic [REG_AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_check(input logic [REG_AW-1:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    reg_addr = a;
    #1;
    check(reg_rdata == exp, tag, "register read", reg_rdata, exp);
  endtask

  task automatic lookup(input logic [BUS_AW-1:0] a, input logic [PA_W-1:0] ep,
                        input logic ef, input logic ec, input logic epr,
                        input bit lat, input string tag);
    exp_t e;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    e.paddr = ep; e.fault = ef; e.cached = ec; e.prio = epr;
    e.chk_lat = lat; e.issue = cyc;
    sb.push_back(e);
    sb_tag.push_back(tag);
    req_valid = 1'b1;
    req_addr  = a;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic walk(input logic [31:0] l1, input logic [BUS_AW-1:0] a,
                      input logic [31:0] l2, input bit store, input string tag);
    logic [PA_W-1:0] ma;
    ma = l2_addr(l1, a);
    if (store) l2mem[ma] = l2;
    mem_exp.push_back(ma);
    if (l2[31])
      lookup(a, l2_pa(l2, a), 1'b0, l2[30], 1'b0, 1'b0, tag);
    else
      lookup(a, '0, 1'b1, 1'b0, 1'b0, 1'b0, tag);
  endtask

  task automatic drain();
    while (sb.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  // response monitor (scoreboard)
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (rst_n && resp_valid && resp_ready) begin
        if (sb.size() == 0) begin
          check(1'b0, "R9", "response with none due", resp_paddr, 64'd0);
        end else begin
          exp_t e;
          string t;
          e = sb.pop_front();
          t = sb_tag.pop_front();
          check(resp_paddr == e.paddr, t, "paddr", resp_paddr, e.paddr);
          check({resp_fault, resp_cached, resp_prio} == {e.fault, e.cached, e.prio},
                t, "fault/cached/prio", {resp_fault, resp_cached, resp_prio},
                {e.fault, e.cached, e.prio});
          if (e.chk_lat)
            check(cyc - e.issue == 1, t, "latency", cyc - e.issue, 1);
        end
      end
    end
  end

  // memory model
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (rst_n && mem_req_valid && mem_req_ready) begin
        logic [PA_W-1:0] a;
        logic [31:0]     d;
        a = mem_req_addr;
        if (mem_exp.size() == 0) begin
          check(1'b0, "R6", "memory read with none due", a, 64'd0);
        end else begin
          logic [PA_W-1:0] x;
          x = mem_exp.pop_front();
          check(a == x, "R6", "memory read address", a, x);
        end
        d = l2mem.exists(a) ? l2mem[a] : 32'h0;
        @(negedge clk);
        #1;
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = d;
        @(negedge clk);
        #1;
        mem_rsp_valid = 1'b0;
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL R9 watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  localparam logic [31:0] LP3  = {2'b11, 17'h1ABCD, 11'h000, 2'b10};
  localparam logic [31:0] LP7  = {2'b11, 17'h00042, 11'h000, 2'b00};
  localparam logic [31:0] LP63 = {2'b11, 17'h1FFFF, 11'h7FF, 2'b01};
  localparam logic [31:0] TP1  = {2'b01, 30'h0012345F};
  localparam logic [31:0] BAD5 = {2'b10, 30'h00000003};

  function automatic logic [REG_AW-1:0] l1_reg(input int i);
    return REG_AW'(9'h100 + 4 * i);
  endfunction

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    check(req_ready == 1'b1, "R1", "req_ready", req_ready, 1);
    check(resp_valid == 1'b0, "R1", "resp_valid", resp_valid, 0);
    check(mem_req_valid == 1'b0, "R1", "mem_req_valid", mem_req_valid, 0);
    reg_check(9'h000, 32'h0, "R1");
    reg_check(9'h004, 32'h0, "R1");
    reg_check(l1_reg(5), 32'h0, "R1");

    // R2 pass-through while disabled
    lookup(37'h1_2345_6789, PA_W'(37'h1_2345_6789), 1'b0, 1'b0, 1'b0, 1'b1, "R2");
    drain();

    // R10 register decode
    reg_write(9'h000, 32'hFFFF_FFFF);
    reg_check(9'h000, 32'h0000_0100, "R10");
    reg_write(9'h004, 32'hFFFF_FFFF);
    reg_check(9'h004, 32'h0000_0003, "R10");
    reg_write(9'h008, 32'hDEAD_BEEF);
    reg_check(9'h008, 32'h0, "R10");
    reg_check(9'h004, 32'h0000_0003, "R10");
    reg_write(l1_reg(10), 32'hA5A5_5A5A);
    reg_check(l1_reg(10), 32'hA5A5_5A5A, "R10");

    // configure: 2 GB window, enabled
    reg_write(9'h004, 32'h1);
    reg_write(9'h000, 32'h100);
    reg_write(l1_reg(0), 32'h0);
    reg_write(l1_reg(1), TP1);
    reg_write(l1_reg(3), LP3);
    reg_write(l1_reg(5), BAD5);
    reg_write(l1_reg(7), LP7);
    reg_write(l1_reg(63), LP63);

    // R4 invalid first-level entries
    lookup(37'h0_0000_1234, '0, 1'b1, 1'b0, 1'b0, 1'b1, "R4");
    lookup(37'h0_0A00_0040, '0, 1'b1, 1'b0, 1'b0, 1'b1, "R4");

    // R5 large page
    lookup(37'h0_0601_2345, large_pa(LP3, 37'h0_0601_2345), 1'b0, 1'b1, 1'b0, 1'b1, "R5");

    // R6 / R7 table walks
    walk(TP1, 37'h0_02AB_C678, 32'hC00A_BCDE, 1'b1, "R7");
    walk(TP1, 37'h0_0200_1FFF, 32'h8000_0055, 1'b1, "R7");
    walk(TP1, 37'h0_0200_2004, 32'h0, 1'b0, "R7");
    walk(TP1, 37'h0_0200_3010, 32'h7FFF_FFFF, 1'b1, "R7");
    drain();

    // R3 window sizes
    lookup(37'h0_8000_0000, '0, 1'b1, 1'b0, 1'b0, 1'b1, "R3");
    reg_write(9'h004, 32'h0);
    lookup(37'h0_0FFF_FFF0, large_pa(LP7, 37'h0_0FFF_FFF0), 1'b0, 1'b0, 1'b0, 1'b1, "R3");
    lookup(37'h0_1000_0000, '0, 1'b1, 1'b0, 1'b0, 1'b1, "R3");
    reg_write(9'h004, 32'h2);
    lookup(37'h0_1000_0000, '0, 1'b1, 1'b0, 1'b0, 1'b1, "R3");
    lookup(37'h0_0FFF_FFF0, large_pa(LP7, 37'h0_0FFF_FFF0), 1'b0, 1'b0, 1'b0, 1'b1, "R3");
    reg_write(9'h004, 32'h3);
    // R8 aliasing above 2 GB
    lookup(37'h1_0600_0010, large_pa(LP3, 37'h1_0600_0010), 1'b0, 1'b1, 1'b0, 1'b1, "R8");
    lookup(37'h1F_FFFF_FFFF, large_pa(LP63, 37'h1F_FFFF_FFFF), 1'b0, 1'b0, 1'b1, 1'b1, "R8");
    walk(TP1, 37'h10_0200_3ABC, 32'h8000_0777, 1'b1, "R8");
    drain();

    // R9 memory request stall
    mem_req_ready = 1'b0;
    walk(TP1, 37'h0_0200_5123, 32'hC000_1234, 1'b1, "R9");
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      #1;
      check(mem_req_valid && !req_ready, "R9", "mem request held",
            {mem_req_valid, req_ready}, 2'b10);
      check(mem_req_addr == l2_addr(TP1, 37'h0_0200_5123), "R9", "mem address held",
            mem_req_addr, l2_addr(TP1, 37'h0_0200_5123));
    end
    @(negedge clk);
    mem_req_ready = 1'b1;
    drain();

    // R9 response stall
    resp_ready = 1'b0;
    lookup(37'h0_0612_3456, large_pa(LP3, 37'h0_0612_3456), 1'b0, 1'b1, 1'b0, 1'b0, "R9");
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      #1;
      check(resp_valid && !req_ready, "R9", "response held",
            {resp_valid, req_ready}, 2'b10);
      check(resp_paddr == large_pa(LP3, 37'h0_0612_3456), "R9", "paddr held",
            resp_paddr, large_pa(LP3, 37'h0_0612_3456));
    end
    @(negedge clk);
    resp_ready = 1'b1;
    drain();

    // R2 again: disabled, table ignored
    reg_write(9'h000, 32'h0);
    lookup(37'h1F_FFFF_FFFF, PA_W'(37'h1F_FFFF_FFFF), 1'b0, 1'b0, 1'b0, 1'b1, "R2");
    lookup(37'h0_0200_0000, PA_W'(37'h0_0200_0000), 1'b0, 1'b0, 1'b0, 1'b1, "R2");
    drain();

    check(mem_exp.size() == 0, "R6", "memory reads outstanding", mem_exp.size(), 0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule